// File: doc/BRIEF.md
# Timer Interrupt Flag Register

This block is an 8-bit memory-mapped register that collects interrupt events from two timer/counters. The second timer supplies three event pulses: compare match A, compare match B and overflow. The first timer supplies one overflow pulse. Each event sets a sticky flag. Software clears a flag by writing a one to its bit.

The interrupt controller also clears a flag when it acknowledges that flag's vector. Each flag is ANDed with its own enable and with the global interrupt enable to form one request line per source.

Clears by write behave differently for the two timers. The first timer's overflow flag clears on the write edge itself. The three flags of the second timer clear one synchronization cycle later, through a pending stage. When a set and a clear meet in the same cycle, the set wins, so no event is lost.

Top module: `timer_irq_flags`

## Requirements
- R1: After reset, whether applied at start-up or asynchronously mid-run, the read data is 0x00 and all four request outputs are low, regardless of the enables.
- R2: An event pulse sets its flag at the next clock edge. The flag positions in the read data are: compare A at bit 6, compare B at bit 5, second-timer overflow at bit 2, first-timer overflow at bit 1.
- R3: Bits 7, 4, 3 and 0 always read as zero. Writing ones to them changes nothing.
- R4: Writing a zero to a flag bit leaves that flag unchanged.
- R5: A write with bit 1 set clears the first-timer overflow flag at the edge that takes the write.
- R6: A write of one to bit 6, 5 or 2 leaves that flag set after the write edge and clears it at the following edge.
- R7: An acknowledge pulse clears its flag at the next edge.
- R8: If a set event coincides with a clear for the same flag, the flag ends up set. This holds for an immediate write clear, an applied pending clear and an acknowledge. A pending clear that loses to an event is consumed and does not act later.
- R9: A request output is high exactly when the global enable, the source enable and the flag are all one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Single-cycle write strobe |
| wr_data_i | input | 8 | Write data; ones clear flags |
| rd_data_o | output | 8 | Current flags, combinational |
| cmpa_evt_i | input | 1 | Second timer compare A match pulse |
| cmpb_evt_i | input | 1 | Second timer compare B match pulse |
| ovf1_evt_i | input | 1 | Second timer overflow pulse |
| ovf0_evt_i | input | 1 | First timer overflow pulse |
| cmpa_ack_i | input | 1 | Vector acknowledge, compare A |
| cmpb_ack_i | input | 1 | Vector acknowledge, compare B |
| ovf1_ack_i | input | 1 | Vector acknowledge, second-timer overflow |
| ovf0_ack_i | input | 1 | Vector acknowledge, first-timer overflow |
| gie_i | input | 1 | Global interrupt enable |
| cmpa_ie_i | input | 1 | Enable, compare A |
| cmpb_ie_i | input | 1 | Enable, compare B |
| ovf1_ie_i | input | 1 | Enable, second-timer overflow |
| ovf0_ie_i | input | 1 | Enable, first-timer overflow |
| cmpa_irq_o | output | 1 | Request, compare A |
| cmpb_irq_o | output | 1 | Request, compare B |
| ovf1_irq_o | output | 1 | Request, second-timer overflow |
| ovf0_irq_o | output | 1 | Request, first-timer overflow |

## Verification
The bench builds the block with its default parameters: a one-cycle clear delay for the second timer's flags and no delay for the first timer's flag. This brings both clear variants within reach in one build. The sampling one cycle after a write separates a delayed clear from an immediate one. The same defaults let a pending clear be made to coincide with a fresh event, which shows that the set wins and that the pending clear is consumed.

// File: rtl/tifr_pkg.sv
package tifr_pkg;
  localparam int NFLAG = 4;
  // flag index: 3 cmpa, 2 cmpb, 1 ovf1, 0 ovf0
  localparam int FLAG_POS [NFLAG] = '{1, 2, 5, 6};

  function automatic logic [7:0] flag_mask();
    logic [7:0] m;
    m = '0;
    for (int i = 0; i < NFLAG; i++) m[FLAG_POS[i]] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/tifr_flag_cell.sv
module tifr_flag_cell #(
  parameter int CLR_DLY = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic wr_clr_i,
  input  logic ack_i,
  output logic flag_o
);
  logic flag_q;
  logic clr_w;

  generate
    if (CLR_DLY == 0) begin : g_imm
      assign clr_w = wr_clr_i;
    end else begin : g_dly
      logic [CLR_DLY-1:0] pend_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          pend_q <= '0;
        end else begin
          pend_q[0] <= wr_clr_i;
          for (int k = 1; k < CLR_DLY; k++) pend_q[k] <= pend_q[k-1];
        end
      end
      assign clr_w = pend_q[CLR_DLY-1];
    end
  endgenerate

  // set has priority over any clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  flag_q <= 1'b0;
    else if (set_i)               flag_q <= 1'b1;
    else if (clr_w || ack_i)      flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/tifr_irq_gate.sv
module tifr_irq_gate #(
  parameter int N = 4
) (
  input  logic         gie_i,
  input  logic [N-1:0] ie_i,
  input  logic [N-1:0] flag_i,
  output logic [N-1:0] irq_o
);
  always_comb begin
    for (int i = 0; i < N; i++) irq_o[i] = gie_i & ie_i[i] & flag_i[i];
  end
endmodule

// File: rtl/timer_irq_flags.sv
module timer_irq_flags #(
  parameter int DATA_W     = 8,
  parameter int T1_CLR_DLY = 1,
  parameter int T0_CLR_DLY = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              cmpa_evt_i,
  input  logic              cmpb_evt_i,
  input  logic              ovf1_evt_i,
  input  logic              ovf0_evt_i,
  input  logic              cmpa_ack_i,
  input  logic              cmpb_ack_i,
  input  logic              ovf1_ack_i,
  input  logic              ovf0_ack_i,
  input  logic              gie_i,
  input  logic              cmpa_ie_i,
  input  logic              cmpb_ie_i,
  input  logic              ovf1_ie_i,
  input  logic              ovf0_ie_i,
  output logic              cmpa_irq_o,
  output logic              cmpb_irq_o,
  output logic              ovf1_irq_o,
  output logic              ovf0_irq_o
);
  import tifr_pkg::*;

  localparam logic [7:0] USED_MASK = flag_mask();
  localparam logic [DATA_W-1:0] RSVD_MASK = DATA_W'(~USED_MASK);

  logic [NFLAG-1:0] evt_w, ack_w, ie_w, flag_w, irq_w, wclr_w;
  logic             unused_rsvd;

  assign evt_w = {cmpa_evt_i, cmpb_evt_i, ovf1_evt_i, ovf0_evt_i};
  assign ack_w = {cmpa_ack_i, cmpb_ack_i, ovf1_ack_i, ovf0_ack_i};
  assign ie_w  = {cmpa_ie_i,  cmpb_ie_i,  ovf1_ie_i,  ovf0_ie_i};

  assign unused_rsvd = ^(wr_data_i & RSVD_MASK);

  generate
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      localparam int DLY = (i == 0) ? T0_CLR_DLY : T1_CLR_DLY;
      assign wclr_w[i] = wr_en_i & wr_data_i[FLAG_POS[i]];
      tifr_flag_cell #(.CLR_DLY(DLY)) u_cell (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .set_i    (evt_w[i]),
        .wr_clr_i (wclr_w[i]),
        .ack_i    (ack_w[i]),
        .flag_o   (flag_w[i])
      );
    end
  endgenerate

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NFLAG; i++) rd_data_o[FLAG_POS[i]] = flag_w[i];
  end

  tifr_irq_gate #(.N(NFLAG)) u_gate (
    .gie_i  (gie_i),
    .ie_i   (ie_w),
    .flag_i (flag_w),
    .irq_o  (irq_w)
  );

  assign {cmpa_irq_o, cmpb_irq_o, ovf1_irq_o, ovf0_irq_o} = irq_w;
endmodule

// File: rtl/tifr_checker.sv
module tifr_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [7:0] wr_data_i,
  input logic [7:0] rd_data_o,
  input logic [3:0] evt_i,
  input logic [3:0] ack_i,
  input logic       gie_i,
  input logic [3:0] irq_o
);
  // R3
  a_r3_rsvd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o & 8'h99) == 8'h00);

  // R2
  a_r2_cmpa_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i[3] |=> rd_data_o[6]);
  a_r2_ovf0_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i[0] |=> rd_data_o[1]);

  // R5
  a_r5_ovf0_imm_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[1] && !evt_i[0]) |=> !rd_data_o[1]);

  // R6
  a_r6_cmpa_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[6] && rd_data_o[6] && !ack_i[3]) |=> rd_data_o[6]);

  // R7
  a_r7_ack_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i[2] && !evt_i[2]) |=> !rd_data_o[5]);

  // R9
  a_r9_irq_gie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o != 4'b0000) |-> gie_i);
  a_r9_irq_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o[1] |-> rd_data_o[2]);
endmodule

bind timer_irq_flags tifr_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .rd_data_o (rd_data_o),
  .evt_i     ({cmpa_evt_i, cmpb_evt_i, ovf1_evt_i, ovf0_evt_i}),
  .ack_i     ({cmpa_ack_i, cmpb_ack_i, ovf1_ack_i, ovf0_ack_i}),
  .gie_i     (gie_i),
  .irq_o     ({cmpa_irq_o, cmpb_irq_o, ovf1_irq_o, ovf0_irq_o})
);

// File: tb/timer_irq_flags_bench.sv
module timer_irq_flags_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [3:0] evt = '0, ack = '0, ie = '0;
  logic       gie = 1'b0;
  logic [7:0] rd;
  logic [3:0] irq;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  timer_irq_flags u_timer_irq_flags (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd),
    .cmpa_evt_i(evt[3]), .cmpb_evt_i(evt[2]), .ovf1_evt_i(evt[1]), .ovf0_evt_i(evt[0]),
    .cmpa_ack_i(ack[3]), .cmpb_ack_i(ack[2]), .ovf1_ack_i(ack[1]), .ovf0_ack_i(ack[0]),
    .gie_i(gie),
    .cmpa_ie_i(ie[3]), .cmpb_ie_i(ie[2]), .ovf1_ie_i(ie[1]), .ovf0_ie_i(ie[0]),
    .cmpa_irq_o(irq[3]), .cmpb_irq_o(irq[2]), .ovf1_irq_o(irq[1]), .ovf0_irq_o(irq[0])
  );

  // {req, wr, data, evt, ack, gie, ie, exp_rd, exp_irq}; 4-bit groups: cmpa,cmpb,ovf1,ovf0
  localparam int NV = 24;
  localparam logic [37:0] VEC [NV] = '{
    {4'd2, 1'b0, 8'h00, 4'b1111, 4'b0000, 1'b1, 4'b1111, 8'h66, 4'b1111}, // R2
    {4'd9, 1'b0, 8'h00, 4'b0000, 4'b0000, 1'b0, 4'b1111, 8'h66, 4'b0000}, // R9
    {4'd9, 1'b0, 8'h00, 4'b0000, 4'b0000, 1'b1, 4'b0101, 8'h66, 4'b0101}, // R9
    {4'd4, 1'b1, 8'h00, 4'b0000, 4'b0000, 1'b0, 4'b0000, 8'h66, 4'b0000}, // R4
    {4'd3, 1'b1, 8'h99, 4'b0000, 4'b0000, 1'b0, 4'b0000, 8'h66, 4'b0000}, // R3
    {4'd5, 1'b1, 8'h02, 4'b0000, 4'b0000, 1'b0, 4'b0000, 8'h64, 4'b0000}, // R5
    {4'd6, 1'b1, 8'h40, 4'b0000, 4'b0000, 1'b0, 4'b0000, 8'h64, 4'b0000}, // R6
    {4'd6, 1'b0, 8'h00, 4'b0000, 4'b0000, 1'b0, 4'b0000, 8'h24, 4'b0000}, // R6
    {4'd6, 1'b1, 8'h24, 4'b0000, 4'b0000, 1'b0, 4'b0000, 8'h24, 4'b0000}, // R6
    {4'd6, 1'b0, 8'h00, 4'b0000, 4'b0000, 1'b0, 4'b0000, 8'h00, 4'b0000}, // R6
    {4'd2, 1'b0, 8'h00, 4'b0001, 4'b0000, 1'b0, 4'b0000, 8'h02, 4'b0000}, // R2
    {4'd7, 1'b0, 8'h00, 4'b0000, 4'b0001, 1'b0, 4'b0000, 8'h00, 4'b0000}, // R7
    {4'd2, 1'b0, 8'h00, 4'b1000, 4'b0000, 1'b0, 4'b0000, 8'h40, 4'b0000}, // R2
    {4'd8, 1'b0, 8'h00, 4'b1000, 4'b1000, 1'b0, 4'b0000, 8'h40, 4'b0000}, // R8 ack
    {4'd7, 1'b0, 8'h00, 4'b0000, 4'b1000, 1'b0, 4'b0000, 8'h00, 4'b0000}, // R7
    {4'd8, 1'b1, 8'h02, 4'b0001, 4'b0000, 1'b0, 4'b0000, 8'h02, 4'b0000}, // R8 imm
    {4'd5, 1'b1, 8'h02, 4'b0000, 4'b0000, 1'b0, 4'b0000, 8'h00, 4'b0000}, // R5
    {4'd2, 1'b0, 8'h00, 4'b0010, 4'b0000, 1'b0, 4'b0000, 8'h04, 4'b0000}, // R2
    {4'd6, 1'b1, 8'h04, 4'b0000, 4'b0000, 1'b0, 4'b0000, 8'h04, 4'b0000}, // R6
    {4'd8, 1'b0, 8'h00, 4'b0010, 4'b0000, 1'b0, 4'b0000, 8'h04, 4'b0000}, // R8 pend
    {4'd8, 1'b0, 8'h00, 4'b0000, 4'b0000, 1'b0, 4'b0000, 8'h04, 4'b0000}, // R8 consumed
    {4'd7, 1'b0, 8'h00, 4'b0000, 4'b0110, 1'b0, 4'b0000, 8'h00, 4'b0000}, // R7
    {4'd9, 1'b0, 8'h00, 4'b0100, 4'b0000, 1'b1, 4'b0100, 8'h20, 4'b0100}, // R9
    {4'd7, 1'b0, 8'h00, 4'b0000, 4'b0100, 1'b1, 4'b0100, 8'h00, 4'b0000}  // R7
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    wr_en = 1'b0; wr_data = '0; evt = '0; ack = '0;
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    gie = 1'b1; ie = 4'hF;
    #1;
    check("R1 reset rd", rd, 8'h00);
    check("R1 reset irq", {4'h0, irq}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    for (int n = 0; n < NV; n++) begin
      logic [37:0] v;
      v = VEC[n];
      @(negedge clk);
      wr_en = v[33]; wr_data = v[32:25]; evt = v[24:21]; ack = v[20:17];
      gie = v[16]; ie = v[15:12];
      @(posedge clk);
      #1;
      check($sformatf("R%0d vec%0d rd", v[37:34], n), rd, v[11:4]);
      check($sformatf("R%0d vec%0d irq", v[37:34], n), {4'h0, irq}, {4'h0, v[3:0]});
    end

    // directed: asynchronous reset mid-run (R1)
    @(negedge clk);
    idle(); evt = 4'hF; gie = 1'b1; ie = 4'hF;
    @(negedge clk);
    idle();
    #1;
    check("R1 pre", rd, 8'h66);
    rst_n = 1'b0;
    #1;
    check("R1 async rd", rd, 8'h00);
    check("R1 async irq", {4'h0, irq}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    // directed: delayed clear of cmpb alone, others untouched (R6, R4)
    @(negedge clk);
    evt = 4'b0101;
    @(negedge clk);
    idle(); wr_en = 1'b1; wr_data = 8'h20;
    @(posedge clk); #1;
    check("R6 cmpb held", rd, 8'h22);
    @(negedge clk);
    idle();
    @(posedge clk); #1;
    check("R6 cmpb cleared", rd, 8'h02);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule